// File: doc/BRIEF.md
# Coprocessor Instruction Access Gate

This block stands between instruction decode and a SIMD/floating-point coprocessor. For each decoded coprocessor instruction, marked by a valid strobe, it produces one of three verdicts in the same cycle: pass the instruction to the execution unit, raise an undefined-instruction exception, or trap to the hypervisor. The verdict depends on the current privilege, the security state, and the hypervisor state. It also depends on the access, non-secure and trap fields that system control registers supply for coprocessors 10 and 11. The two coprocessors must agree: if either one's field refuses the access, the instruction is refused.

The block holds a small exception-control register. That register has one global enable bit, and the bit is clear after reset. While the bit is clear, almost everything is refused. Privileged software can still write the control and system-ID registers, and it can still read the control, system-ID and two feature-ID registers. This lets it discover the unit and switch it on. The ID registers are constants. Reads return data on a combinational read port in the same cycle as the verdict.

Top module: `cp_access_gate`

## Requirements
- R1: After a synchronous reset, the enable bit (bit 30 of the control register) is 0. A privileged read of the control register then returns 0.
- R2: When `instr_valid` is high, exactly one of `allow`, `undef` and `hyp_trap` is high. When `instr_valid` is low, all three are low.
- R3: Each coprocessor has a 2-bit access field. The value 00 denies all access. The value 01 allows privileged access only. The value 10 denies all access. The value 11 allows all access. If the field of either coprocessor does not permit the current privilege, the result is `undef`.
- R4: In non-secure state (`nonsecure`=1), both non-secure access bits must be 1. Otherwise the result is `undef`.
- R5: Once R3 and R4 pass, `hyp_active`=1 together with either trap bit set gives `hyp_trap`. This check takes priority over the enable-bit and whitelist checks.
- R6: With the enable bit set, the following pass: data operations (class 0), moves to the system-ID or control register (class 1, select 0 or 1), and moves from the system-ID, control, feature-0 or feature-1 register (class 2, select 0 to 3). Class 3, and any other select value, gives `undef`.
- R7: With the enable bit clear, data operations give `undef`. Privileged moves to select 0 or 1, and privileged moves from select 0 to 3, still pass.
- R8: With the enable bit clear, a whitelisted move from user privilege (`priv`=0) gives `undef`.
- R9: An allowed move to the control register loads the enable bit from `wr_data[30]` on the next clock edge. Reads of the control register return the enable bit at bit 30 and zeros everywhere else.
- R10: The system-ID and feature registers return their parameter constants. An allowed move to the system-ID register is accepted but changes nothing.
- R11: `rd_data` carries the selected register on an allowed move-from. In every other case it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | A decoded coprocessor instruction is present |
| priv | input | 1 | 1 = privileged mode, 0 = user |
| nonsecure | input | 1 | 1 = non-secure state |
| hyp_active | input | 1 | 1 = hypervisor trap controls apply |
| acr_cp10 | input | 2 | Access field for coprocessor 10 |
| acr_cp11 | input | 2 | Access field for coprocessor 11 |
| ns_cp10 | input | 1 | Non-secure access bit, coprocessor 10 |
| ns_cp11 | input | 1 | Non-secure access bit, coprocessor 11 |
| trap_cp10 | input | 1 | Hypervisor trap bit, coprocessor 10 |
| trap_cp11 | input | 1 | Hypervisor trap bit, coprocessor 11 |
| instr_class | input | 2 | 0 data op, 1 move-to register, 2 move-from register, 3 reserved |
| sysreg_sel | input | 3 | 0 system-ID, 1 control, 2 feature-0, 3 feature-1 |
| wr_data | input | 32 | Data for move-to |
| allow | output | 1 | Pass the instruction to execution |
| undef | output | 1 | Raise an undefined-instruction exception |
| hyp_trap | output | 1 | Trap to hypervisor |
| rd_data | output | 32 | Read data for move-from |

## Verification
The control-register write and the verdict can fall in the same cycle. An allowed move that clears or sets the enable bit also decides how the very next instruction is judged. To provoke this, the bench runs random back-to-back instruction streams, with control writes mixed among data operations and whitelisted moves. A reference model updates its enable state only after judging the instruction that wrote it. In the same way, a hypervisor trap and a cleared enable bit can apply to the same instruction. Directed cases put both in force and expect `hyp_trap`, not `undef`.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    localparam int DATA_W  = 32;
    localparam int SEL_W   = 3;
    localparam int EN_BIT  = 30;

    typedef enum logic [1:0] {
        CLS_DATA      = 2'd0,
        CLS_MOVE_TO   = 2'd1,
        CLS_MOVE_FROM = 2'd2,
        CLS_RSVD      = 2'd3
    } cls_e;

    localparam logic [SEL_W-1:0] SEL_SYSID = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_FEAT0 = 3'd2;
    localparam logic [SEL_W-1:0] SEL_FEAT1 = 3'd3;

    typedef enum logic [1:0] {
        V_NONE  = 2'd0,
        V_ALLOW = 2'd1,
        V_UNDEF = 2'd2,
        V_HYP   = 2'd3
    } verdict_e;

    typedef struct packed {
        logic [1:0] acr;
        logic       ns_ok;
        logic       trap;
    } cp_ctl_t;

    function automatic logic field_permits(input logic [1:0] f, input logic priv);
        return (f == 2'b11) || (f == 2'b01 && priv);
    endfunction

endpackage

// File: rtl/cpg_perm.sv
module cpg_perm
    import cpg_pkg::*;
#(
    parameter int N_CP = 2
) (
    input  logic             priv,
    input  logic             nonsecure,
    input  logic             hyp_active,
    input  cp_ctl_t [N_CP-1:0] ctl,
    output logic             base_ok,
    output logic             trap_hit
);
    logic [N_CP-1:0] acr_ok;
    logic [N_CP-1:0] ns_ok;
    logic [N_CP-1:0] trap_v;

    for (genvar i = 0; i < N_CP; i++) begin : g_cp
        assign acr_ok[i] = field_permits(ctl[i].acr, priv);
        assign ns_ok[i]  = !nonsecure || ctl[i].ns_ok;
        assign trap_v[i] = ctl[i].trap;
    end

    assign base_ok  = (&acr_ok) && (&ns_ok);
    assign trap_hit = hyp_active && (|trap_v);

endmodule

// File: rtl/cpg_filter.sv
module cpg_filter
    import cpg_pkg::*;
(
    input  logic             en,
    input  logic             priv,
    input  cls_e             cls,
    input  logic [SEL_W-1:0] sel,
    output logic             pass
);
    logic wr_known;
    logic rd_known;
    logic move_ok;

    always_comb begin
        wr_known = (sel == SEL_SYSID) || (sel == SEL_CTRL);
        rd_known = wr_known || (sel == SEL_FEAT0) || (sel == SEL_FEAT1);
        move_ok  = (cls == CLS_MOVE_TO && wr_known) ||
                   (cls == CLS_MOVE_FROM && rd_known);
        if (en)
            pass = (cls == CLS_DATA) || move_ok;
        else
            pass = priv && move_ok;
    end

endmodule

// File: rtl/cpg_ctrl.sv
module cpg_ctrl
    import cpg_pkg::*;
#(
    parameter logic [DATA_W-1:0] SYSID_VAL = 32'h00A5_1230,
    parameter logic [DATA_W-1:0] FEAT0_VAL = 32'h1011_0222,
    parameter logic [DATA_W-1:0] FEAT1_VAL = 32'h0111_1111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic              en,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst)
            en <= 1'b0;
        else if (wr_en)
            en <= wr_data[EN_BIT];
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (rd_sel)
                SEL_SYSID: rd_data = SYSID_VAL;
                SEL_CTRL:  rd_data[EN_BIT] = en;
                SEL_FEAT0: rd_data = FEAT0_VAL;
                SEL_FEAT1: rd_data = FEAT1_VAL;
                default:   rd_data = '0;
            endcase
        end
    end

    // A control write lands on the next edge
    assert_ctrl_load_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (en == $past(wr_data[EN_BIT])));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(en));

endmodule

// File: rtl/cp_access_gate.sv
module cp_access_gate
    import cpg_pkg::*;
#(
    parameter logic [31:0] SYSID_VAL = 32'h00A5_1230,
    parameter logic [31:0] FEAT0_VAL = 32'h1011_0222,
    parameter logic [31:0] FEAT1_VAL = 32'h0111_1111
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        instr_valid,
    input  logic        priv,
    input  logic        nonsecure,
    input  logic        hyp_active,
    input  logic [1:0]  acr_cp10,
    input  logic [1:0]  acr_cp11,
    input  logic        ns_cp10,
    input  logic        ns_cp11,
    input  logic        trap_cp10,
    input  logic        trap_cp11,
    input  logic [1:0]  instr_class,
    input  logic [2:0]  sysreg_sel,
    input  logic [31:0] wr_data,
    output logic        allow,
    output logic        undef,
    output logic        hyp_trap,
    output logic [31:0] rd_data
);
    localparam int N_CP = 2;

    cp_ctl_t [N_CP-1:0] ctl;
    cls_e               cls;
    logic               base_ok;
    logic               trap_hit;
    logic               pass;
    logic               en;
    verdict_e           verdict;
    logic               wr_ctrl;
    logic               rd_ok;

    assign ctl[0] = '{acr: acr_cp10, ns_ok: ns_cp10, trap: trap_cp10};
    assign ctl[1] = '{acr: acr_cp11, ns_ok: ns_cp11, trap: trap_cp11};
    assign cls    = cls_e'(instr_class);

    cpg_perm #(.N_CP(N_CP)) u_perm (
        .priv       (priv),
        .nonsecure  (nonsecure),
        .hyp_active (hyp_active),
        .ctl        (ctl),
        .base_ok    (base_ok),
        .trap_hit   (trap_hit)
    );

    cpg_filter u_filter (
        .en   (en),
        .priv (priv),
        .cls  (cls),
        .sel  (sysreg_sel),
        .pass (pass)
    );

    // Order of checks: access fields, then hypervisor trap, then enable/whitelist
    always_comb begin
        if (!instr_valid)   verdict = V_NONE;
        else if (!base_ok)  verdict = V_UNDEF;
        else if (trap_hit)  verdict = V_HYP;
        else if (pass)      verdict = V_ALLOW;
        else                verdict = V_UNDEF;
    end

    assign allow    = (verdict == V_ALLOW);
    assign undef    = (verdict == V_UNDEF);
    assign hyp_trap = (verdict == V_HYP);

    assign wr_ctrl = allow && (cls == CLS_MOVE_TO) && (sysreg_sel == SEL_CTRL);
    assign rd_ok   = allow && (cls == CLS_MOVE_FROM);

    cpg_ctrl #(
        .SYSID_VAL (SYSID_VAL),
        .FEAT0_VAL (FEAT0_VAL),
        .FEAT1_VAL (FEAT1_VAL)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ctrl),
        .wr_data (wr_data),
        .rd_en   (rd_ok),
        .rd_sel  (sysreg_sel),
        .en      (en),
        .rd_data (rd_data)
    );

    assert_reset_off_R1: assert property (@(posedge clk)
        rst |=> !en);

    assert_one_verdict_R2: assert property (@(posedge clk) disable iff (rst)
        instr_valid |-> $countones({allow, undef, hyp_trap}) == 1);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !(allow || undef || hyp_trap));

    assert_user_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !en && !priv) |-> !allow);

    assert_trap_first_R5: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && base_ok && trap_hit) |-> hyp_trap);

    assert_access_fields_R3: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !base_ok) |-> undef);

    assert_rd_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !allow |-> rd_data == '0);

endmodule

// File: tb/sim_cp_access_gate.sv
module sim_cp_access_gate;

    localparam logic [31:0] SYSID = 32'h00A5_1230;
    localparam logic [31:0] FEAT0 = 32'h1011_0222;
    localparam logic [31:0] FEAT1 = 32'h0111_1111;

    logic        clk = 0;
    logic        rst;
    logic        instr_valid, priv, nonsecure, hyp_active;
    logic [1:0]  acr_cp10, acr_cp11;
    logic        ns_cp10, ns_cp11, trap_cp10, trap_cp11;
    logic [1:0]  instr_class;
    logic [2:0]  sysreg_sel;
    logic [31:0] wr_data;
    logic        allow, undef, hyp_trap;
    logic [31:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit m_en  = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    cp_access_gate u0 (.*);

    function automatic bit fld_ok(logic [1:0] f, logic p);
        return (f == 2'b11) || (f == 2'b01 && p);
    endfunction

    // returns {allow, undef, trap}
    function automatic logic [2:0] exp_verdict();
        bit base, wl;
        if (!instr_valid) return 3'b000;
        base = fld_ok(acr_cp10, priv) && fld_ok(acr_cp11, priv) &&
               (!nonsecure || (ns_cp10 && ns_cp11));
        if (!base) return 3'b010;
        if (hyp_active && (trap_cp10 || trap_cp11)) return 3'b001;
        wl = (instr_class == 2'd1 && sysreg_sel <= 3'd1) ||
             (instr_class == 2'd2 && sysreg_sel <= 3'd3);
        if (m_en) return (instr_class == 2'd0 || wl) ? 3'b100 : 3'b010;
        return (priv && wl) ? 3'b100 : 3'b010;
    endfunction

    function automatic logic [31:0] exp_rd(logic [2:0] v);
        if (!(v[2] && instr_class == 2'd2)) return 32'h0;
        case (sysreg_sel)
            3'd0: return SYSID;
            3'd1: return {1'b0, m_en, 30'h0};
            3'd2: return FEAT0;
            3'd3: return FEAT1;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] v);
        if (!instr_valid) return "R2";
        if (v == 3'b001) return "R5";
        if (!(fld_ok(acr_cp10, priv) && fld_ok(acr_cp11, priv))) return "R3";
        if (nonsecure && !(ns_cp10 && ns_cp11)) return "R4";
        if (!m_en && !priv && instr_class != 2'd0) return "R8";
        return m_en ? "R6" : "R7";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, judge 1 ns later, model update follows the edge
    task automatic step();
        logic [2:0] v;
        #1;
        v = exp_verdict();
        check(tag_of(v), {29'h0, allow, undef, hyp_trap}, {29'h0, v});
        check("R11", rd_data, exp_rd(v));
        @(posedge clk);
        if (v[2] && instr_class == 2'd1 && sysreg_sel == 3'd1) m_en = wr_data[30];
        @(negedge clk);
    endtask

    task automatic set_open();
        instr_valid = 1; priv = 1; nonsecure = 0; hyp_active = 0;
        acr_cp10 = 2'b11; acr_cp11 = 2'b11; ns_cp10 = 1; ns_cp11 = 1;
        trap_cp10 = 0; trap_cp11 = 0; wr_data = 0;
    endtask

    task automatic op(logic [1:0] c, logic [2:0] s, logic [31:0] d);
        instr_class = c; sysreg_sel = s; wr_data = d;
        step();
    endtask

    initial begin
        #800000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        set_open(); instr_valid = 0; instr_class = 0; sysreg_sel = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; m_en = 0;

        op(2'd0, 3'd0, 0);                 // R2 idle strobe low
        instr_valid = 1;
        op(2'd2, 3'd1, 0);                 // R1 control reads 0 after reset
        check("R1", rd_data, 32'h0);
        op(2'd0, 3'd0, 0);                 // R7 data op undefined while off
        priv = 0; op(2'd2, 3'd0, 0);       // R8 user read of ID
        priv = 1;
        op(2'd1, 3'd0, 32'hFFFF_FFFF);     // R10 write to system-ID ignored
        op(2'd2, 3'd0, 0);
        op(2'd1, 3'd1, 32'h4000_0000);     // R9 turn on
        op(2'd2, 3'd1, 0);
        check("R9", rd_data, 32'h4000_0000);
        op(2'd0, 3'd0, 0);                 // R6 data op allowed
        op(2'd3, 3'd0, 0);                 // R6 reserved class
        op(2'd2, 3'd5, 0);                 // R6 unknown register
        op(2'd1, 3'd2, 32'hFFFF_FFFF);     // R6 write to feature reg refused
        op(2'd2, 3'd3, 0);                 // R10 feature-1 constant
        hyp_active = 1; trap_cp11 = 1;
        op(2'd0, 3'd0, 0);                 // R5 trap while enabled
        op(2'd1, 3'd1, 32'h0);             // R5 trap blocks write
        op(2'd2, 3'd1, 0);
        hyp_active = 0; trap_cp11 = 0;
        op(2'd1, 3'd1, 32'hBFFF_FFFF);     // R9 turn off via bit 30
        hyp_active = 1; trap_cp10 = 1;
        op(2'd0, 3'd0, 0);                 // R5 priority over disabled unit
        hyp_active = 0; trap_cp10 = 0;
        acr_cp11 = 2'b01; priv = 0;
        op(2'd2, 3'd1, 0);                 // R3 privileged-only field
        acr_cp11 = 2'b10; priv = 1;
        op(2'd2, 3'd1, 0);                 // R3 reserved field value
        acr_cp11 = 2'b11; nonsecure = 1; ns_cp11 = 0;
        op(2'd2, 3'd1, 0);                 // R4 missing non-secure bit
        ns_cp11 = 1;
        op(2'd2, 3'd1, 0);                 // R4 both set

        for (int i = 0; i < 3000; i++) begin
            bit [31:0] r = $urandom;
            instr_valid = (r[3:0] != 0);
            priv        = r[4] | r[5];
            nonsecure   = r[6];
            hyp_active  = r[7];
            acr_cp10    = (r[10:8] == 0) ? r[12:11] : 2'b11;
            acr_cp11    = (r[15:13] == 0) ? r[17:16] : 2'b11;
            ns_cp10     = (r[19:18] != 0);
            ns_cp11     = (r[21:20] != 0);
            trap_cp10   = (r[24:22] == 0);
            trap_cp11   = (r[27:25] == 0);
            instr_class = r[29:28];
            sysreg_sel  = r[30] ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 1));
            wr_data     = $urandom;
            step();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule